// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block steers the seven-cycle entry sequence that an 8-bit core shares across four events: the zero-opcode break instruction, reset, the level-sensitive maskable interrupt and the edge-detected non-maskable interrupt. Several mechanisms work independently, each at its own cycle:

- a sticky pending latch records a recognized hardware interrupt;
- at the next opcode fetch that latch replaces the fetched opcode with zero;
- during the status push the break-flag position is driven from the latch;
- a separately latched selection picks the vector pair.

Because these parts act at different times, their known mismatches appear exactly. An interrupt that arrives early in a break sequence takes it over. An NMI that arrives late redirects the vector but leaves the pushed break bit at 1. Reset walks the stack cycles as reads.

The surrounding core supplies the program counter, the status byte, the opcode byte, the fetch strobe and the store and push requests for ordinary instructions. The block drives the following:

- the instruction register;
- the entry step;
- the stack or vector address;
- the pushed data byte;
- a registered read/write strobe.

The ALU, register file and full decoder sit outside.

Top module: `irq_entry_seq`

## Requirements
- R1: After rst_ni is released, step_o is 0, ir_o holds 8'hEA, hw_pend_o is 0, rw_o is 1 (read), and addr_o and db_o are 0.
- R2: A clock edge that samples irq_ni low while i_flag_i is 0 sets hw_pend_o. The latch may be set at any edge except the edge leaving step 5 and edges in step 6. With i_flag_i at 1, a low irq_ni leaves hw_pend_o at 0.
- R3: At an edge in step 0 with sync_i and rdy_i high, ir_o loads 8'h00 if hw_pend_o is set, and opcode_i otherwise. If the loaded value is 8'h00, step_o becomes 2. pc_inc_o is 1 in step 2 only when the zero came from opcode_i.
- R4: An entry runs steps 2 through 7 and then returns to 0. Step 1 is shown while res_i is held. Steps 3, 4 and 5 address 16'h01xx, where xx is a stack pointer that starts at 8'hFF and drops by one after each of those steps.
- R5: db_o carries pc_i[15:8] in step 3 and pc_i[7:0] in step 4. In step 5 it carries status_i with bit 5 forced to 1 and bit 4 as the break bit.
- R6: The pushed break bit (bit 4) is the inverse of hw_pend_o and nothing else. This applies in step 5 and in the cycle after php_push_i. A break whose sequence sees an IRQ latched during step 2 therefore pushes bit 4 = 0 and uses the IRQ/break vector.
- R7: hw_pend_o is cleared at the edge entering step 6 and stays 0 throughout step 6.
- R8: Step 6 addresses the low vector byte and step 7 the byte above it. The pair is 16'hFFFC for reset, 16'hFFFA for NMI, and 16'hFFFE for IRQ and break. set_i_o is 1 in step 6.
- R9: The vector choice is fixed at the edge entering step 6. An NMI pulse during step 6 changes neither vector byte. It stays pending, sets hw_pend_o after step 7, and is then serviced through 16'hFFFA.
- R10: An NMI pulse on nmi_taken_i during step 5 of a break selects 16'hFFFA, while the pushed bit 4 stays 1 and hw_pend_o is 0 afterwards.
- R11: rw_o is registered and is 0 (write) in a cycle that is step 3, 4 or 5, or that follows an edge with op_store_i or php_push_i high. From res_i high until a reset entry leaves step 7, rw_o stays 1.
- R12: An edge with rdy_i low holds step_o and the stack pointer and makes rw_o 1 for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_i | input | 1 | Reset-sequence request from the core |
| irq_ni | input | 1 | Maskable interrupt level, active low |
| i_flag_i | input | 1 | Interrupt mask flag |
| nmi_taken_i | input | 1 | Pulse: a non-maskable edge was detected |
| rdy_i | input | 1 | Ready; low stalls the sequence |
| sync_i | input | 1 | Opcode fetch cycle strobe |
| opcode_i | input | 8 | Opcode byte on the data bus |
| op_store_i | input | 1 | Next cycle is an ordinary memory store |
| php_push_i | input | 1 | Next cycle pushes the status byte |
| pc_i | input | 16 | Program counter to push |
| status_i | input | 8 | Status flags to push |
| ir_o | output | 8 | Instruction register |
| step_o | output | 3 | Entry step, 0 when idle |
| hw_pend_o | output | 1 | Pending hardware interrupt latch |
| pc_inc_o | output | 1 | Step 2 advances the PC past the break |
| set_i_o | output | 1 | Set the interrupt mask |
| addr_o | output | 16 | Stack or vector address |
| db_o | output | 8 | Byte to push |
| rw_o | output | 1 | 1 read, 0 write (registered) |

## Verification
The bench concentrates on the points where the independent mechanisms disagree, because each of them has a characteristic wrong result:

- **IRQ latched during step 2 of a real break.** A design that derived the break bit from the opcode source, rather than from the latch, would push bit 4 = 1 here.
- **NMI during step 5.** A design that folded the NMI into the pending latch too early would push 0. One that sampled the vector late would read 16'hFFFE.
- **NMI during step 6.** A design that re-evaluated the vector each cycle would mix one byte from each vector pair, and one that cleared the NMI on arrival would lose it.
- **Writes during reset, and RDY stalls during a push.** A design that ignores reset or RDY in the strobe would show a write where only reads may happen.

// File: rtl/iseq_pkg.sv
package iseq_pkg;
  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t ST_IDLE    = 3'd0;
  localparam step_t ST_FETCH   = 3'd1;
  localparam step_t ST_DUMMY   = 3'd2;
  localparam step_t ST_PUSH_HI = 3'd3;
  localparam step_t ST_PUSH_LO = 3'd4;
  localparam step_t ST_PUSH_ST = 3'd5;
  localparam step_t ST_VEC_LO  = 3'd6;
  localparam step_t ST_VEC_HI  = 3'd7;

  typedef enum logic [1:0] {VSEL_IRQ, VSEL_NMI, VSEL_RES} vsel_e;

  // low three address bits of the vector's first byte
  function automatic logic [2:0] vsel_code(vsel_e v);
    case (v)
      VSEL_NMI: return 3'b010;
      VSEL_RES: return 3'b100;
      default:  return 3'b110;
    endcase
  endfunction

  function automatic logic is_push(step_t s);
    return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_ST);
  endfunction
endpackage

// File: rtl/iseq_pend.sv
module iseq_pend
  import iseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  irq_ni,
  input  logic  i_flag_i,
  input  logic  nmi_taken_i,
  input  step_t step_i,
  input  logic  enter_vec_i,
  input  logic  res_act_i,
  output logic  hw_pend_o,
  output logic  nmi_now_o
);
  logic hw_q, hw_d;
  logic nmi_q, nmi_d;
  logic irq_src;

  assign irq_src   = !irq_ni && !i_flag_i;
  assign nmi_now_o = nmi_q || nmi_taken_i;

  always_comb begin
    if (enter_vec_i || step_i == ST_VEC_LO) hw_d = 1'b0;
    else                                     hw_d = hw_q || irq_src || nmi_now_o;
    // NMI is consumed only when its vector is the one chosen
    if (enter_vec_i && !res_act_i) nmi_d = 1'b0;
    else                           nmi_d = nmi_now_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      hw_q  <= hw_d;
      nmi_q <= nmi_d;
    end
  end

  assign hw_pend_o = hw_q;
endmodule

// File: rtl/iseq_step.sv
module iseq_step
  import iseq_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] IR_INIT = 8'hEA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_i,
  input  logic              rdy_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic              hw_pend_i,
  output step_t             step_q_o,
  output step_t             step_d_o,
  output logic [DATA_W-1:0] ir_o,
  output logic              res_act_o,
  output logic              res_act_d_o,
  output logic              jammed_o,
  output logic              push_adv_o,
  output logic              enter_vec_o
);
  step_t             step_q, step_d;
  logic [DATA_W-1:0] ir_q, ir_d;
  logic              res_q, res_d;
  logic              jam_q, jam_d;

  always_comb begin
    step_d = step_q;
    ir_d   = ir_q;
    res_d  = res_q;
    jam_d  = jam_q;
    if (res_i) begin
      step_d = ST_FETCH;
      ir_d   = '0;
      res_d  = 1'b1;
      jam_d  = 1'b1;
    end else if (rdy_i) begin
      case (step_q)
        ST_IDLE: if (sync_i) begin
          ir_d  = hw_pend_i ? '0 : opcode_i;
          jam_d = hw_pend_i;
          if (ir_d == '0) step_d = ST_DUMMY;
        end
        ST_VEC_HI: begin
          step_d = ST_IDLE;
          res_d  = 1'b0;
        end
        default: step_d = step_q + 3'd1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      ir_q   <= IR_INIT;
      res_q  <= 1'b0;
      jam_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      ir_q   <= ir_d;
      res_q  <= res_d;
      jam_q  <= jam_d;
    end
  end

  assign step_q_o    = step_q;
  assign step_d_o    = step_d;
  assign ir_o        = ir_q;
  assign res_act_o   = res_q;
  assign res_act_d_o = res_d;
  assign jammed_o    = jam_q;
  assign push_adv_o  = !res_i && rdy_i && is_push(step_q);
  assign enter_vec_o = !res_i && rdy_i && (step_q == ST_PUSH_ST);
endmodule

// File: rtl/iseq_bus.sv
module iseq_bus
  import iseq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                B_POS      = 4,
  parameter int                U_POS      = 5,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT    = 8'hFF,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_t             step_q_i,
  input  step_t             step_d_i,
  input  logic              res_act_i,
  input  logic              res_act_d_i,
  input  logic              rdy_i,
  input  logic              op_store_i,
  input  logic              php_push_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic              hw_pend_i,
  input  logic              enter_vec_i,
  input  logic              nmi_now_i,
  input  logic              push_adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] db_o,
  output logic              rw_o
);
  logic [DATA_W-1:0] sp_q;
  vsel_e             vsel_q;
  logic              rw_q, php_q;
  logic              wr_req;
  logic [DATA_W-1:0] st_push;
  logic [ADDR_W-1:0] vec_lo;

  // write request for the coming cycle, gated by reset-in-progress and RDY
  assign wr_req = op_store_i || php_push_i || is_push(step_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= SP_INIT;
      vsel_q <= VSEL_IRQ;
      rw_q   <= 1'b1;
      php_q  <= 1'b0;
    end else begin
      if (push_adv_i) sp_q <= sp_q - 1'b1;
      if (enter_vec_i) begin
        if (res_act_i)      vsel_q <= VSEL_RES;
        else if (nmi_now_i) vsel_q <= VSEL_NMI;
        else                vsel_q <= VSEL_IRQ;
      end
      rw_q  <= !(wr_req && !res_act_d_i && rdy_i);
      php_q <= php_push_i;
    end
  end

  always_comb begin
    st_push        = status_i;
    st_push[U_POS] = 1'b1;
    st_push[B_POS] = !hw_pend_i;
  end

  assign vec_lo = {{(ADDR_W-3){1'b1}}, vsel_code(vsel_q)};

  always_comb begin
    case (step_q_i)
      ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: addr_o = {STACK_PAGE, sp_q};
      ST_VEC_LO: addr_o = vec_lo;
      ST_VEC_HI: addr_o = vec_lo | {{(ADDR_W-1){1'b0}}, 1'b1};
      default:   addr_o = '0;
    endcase
    case (step_q_i)
      ST_PUSH_HI: db_o = pc_i[ADDR_W-1:DATA_W];
      ST_PUSH_LO: db_o = pc_i[DATA_W-1:0];
      ST_PUSH_ST: db_o = st_push;
      ST_IDLE:    db_o = php_q ? st_push : '0;
      default:    db_o = '0;
    endcase
  end

  assign rw_o = rw_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import iseq_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                B_POS      = 4,
  parameter int                U_POS      = 5,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT    = 8'hFF,
  parameter logic [DATA_W-1:0] IR_INIT    = 8'hEA,
  localparam int               ADDR_W     = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_i,
  input  logic              irq_ni,
  input  logic              i_flag_i,
  input  logic              nmi_taken_i,
  input  logic              rdy_i,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic              op_store_i,
  input  logic              php_push_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] ir_o,
  output logic [2:0]        step_o,
  output logic              hw_pend_o,
  output logic              pc_inc_o,
  output logic              set_i_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] db_o,
  output logic              rw_o
);
  step_t step_q, step_d;
  logic  res_act, res_act_d, jammed, push_adv, enter_vec;
  logic  hw_pend, nmi_now;

  iseq_pend u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_ni      (irq_ni),
    .i_flag_i    (i_flag_i),
    .nmi_taken_i (nmi_taken_i),
    .step_i      (step_q),
    .enter_vec_i (enter_vec),
    .res_act_i   (res_act),
    .hw_pend_o   (hw_pend),
    .nmi_now_o   (nmi_now)
  );

  iseq_step #(.DATA_W(DATA_W), .IR_INIT(IR_INIT)) u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (res_i),
    .rdy_i       (rdy_i),
    .sync_i      (sync_i),
    .opcode_i    (opcode_i),
    .hw_pend_i   (hw_pend),
    .step_q_o    (step_q),
    .step_d_o    (step_d),
    .ir_o        (ir_o),
    .res_act_o   (res_act),
    .res_act_d_o (res_act_d),
    .jammed_o    (jammed),
    .push_adv_o  (push_adv),
    .enter_vec_o (enter_vec)
  );

  iseq_bus #(
    .DATA_W(DATA_W), .B_POS(B_POS), .U_POS(U_POS),
    .STACK_PAGE(STACK_PAGE), .SP_INIT(SP_INIT)
  ) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_q_i    (step_q),
    .step_d_i    (step_d),
    .res_act_i   (res_act),
    .res_act_d_i (res_act_d),
    .rdy_i       (rdy_i),
    .op_store_i  (op_store_i),
    .php_push_i  (php_push_i),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .hw_pend_i   (hw_pend),
    .enter_vec_i (enter_vec),
    .nmi_now_i   (nmi_now),
    .push_adv_i  (push_adv),
    .addr_o      (addr_o),
    .db_o        (db_o),
    .rw_o        (rw_o)
  );

  assign step_o    = step_q;
  assign hw_pend_o = hw_pend;
  assign pc_inc_o  = (step_q == ST_DUMMY) && !jammed;
  assign set_i_o   = (step_q == ST_VEC_LO);
endmodule

// File: rtl/iseq_chk.sv
module iseq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        res_i,
  input logic        rdy_i,
  input logic [2:0]  step_o,
  input logic        hw_pend_o,
  input logic [15:0] addr_o,
  input logic        db_u_i,
  input logic        rw_o,
  input logic        set_i_o
);
  a_r4_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_i && rdy_i && step_o >= 3'd2 && step_o <= 3'd6) |=> (step_o == $past(step_o) + 3'd1));

  a_r12_rdy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_i && !rdy_i) |=> (step_o == $past(step_o)) && rw_o);

  a_r7_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 3'd6) |-> !hw_pend_o);

  a_r5_unused_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 3'd5) |-> db_u_i);

  a_r9_vec_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 3'd7 && $past(step_o) == 3'd6) |-> (addr_o == $past(addr_o) + 16'd1));

  a_r8_vec_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i_o |-> (addr_o[15:8] == 8'hFF) && !addr_o[0]);

  a_r11_reset_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i |=> rw_o);
endmodule

bind irq_entry_seq iseq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .res_i     (res_i),
  .rdy_i     (rdy_i),
  .step_o    (step_o),
  .hw_pend_o (hw_pend_o),
  .addr_o    (addr_o),
  .db_u_i    (db_o[5]),
  .rw_o      (rw_o),
  .set_i_o   (set_i_o)
);

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res = 1'b0, irq_n = 1'b1, i_flag = 1'b0, nmi_taken = 1'b0;
  logic        rdy = 1'b1, sync = 1'b0, op_store = 1'b0, php = 1'b0;
  logic [7:0]  opcode = 8'hEA;
  logic [15:0] pc = 16'h1234;
  logic [7:0]  status = 8'hC3;
  logic [7:0]  ir;
  logic [2:0]  step;
  logic        hw_pend, pc_inc, set_i, rw;
  logic [15:0] addr;
  logic [7:0]  db;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  logic [7:0] sp_m = 8'hFF;

  always #2.5 clk = ~clk;

  irq_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .res_i(res), .irq_ni(irq_n), .i_flag_i(i_flag),
    .nmi_taken_i(nmi_taken), .rdy_i(rdy), .sync_i(sync), .opcode_i(opcode),
    .op_store_i(op_store), .php_push_i(php), .pc_i(pc), .status_i(status),
    .ir_o(ir), .step_o(step), .hw_pend_o(hw_pend), .pc_inc_o(pc_inc),
    .set_i_o(set_i), .addr_o(addr), .db_o(db), .rw_o(rw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pushed_st(input bit b);
    return status | 8'h20 | (b ? 8'h10 : 8'h00);
  endfunction

  // walks steps 2..7; inj_kind 1 = IRQ, 2 = NMI, applied during inj_step
  task automatic walk(input string tag, input logic [15:0] vec, input bit writes,
                      input bit exp_inc, input bit exp_b, input int inj_step, input int inj_kind);
    @(negedge clk);
    for (int s = 2; s <= 7; s++) begin
      nmi_taken = 1'b0;
      irq_n     = 1'b1;
      chk({tag, " R4 step"}, 32'(step), 32'(s));
      case (s)
        2: begin
          sync = 1'b0;
          chk({tag, " R3 ir zero"}, 32'(ir), 32'h0);
          chk({tag, " R3 pc_inc"}, 32'(pc_inc), 32'(exp_inc));
        end
        3: begin
          chk({tag, " R4 addr hi push"}, 32'(addr), {16'h0, 8'h01, sp_m});
          chk({tag, " R11 rw hi push"}, 32'(rw), 32'(!writes));
          chk({tag, " R5 pch"}, 32'(db), 32'(pc[15:8]));
          sp_m--;
        end
        4: begin
          chk({tag, " R4 addr lo push"}, 32'(addr), {16'h0, 8'h01, sp_m});
          chk({tag, " R5 pcl"}, 32'(db), 32'(pc[7:0]));
          sp_m--;
        end
        5: begin
          chk({tag, " R4 addr st push"}, 32'(addr), {16'h0, 8'h01, sp_m});
          chk({tag, " R11 rw st push"}, 32'(rw), 32'(!writes));
          chk({tag, " R6 pushed status"}, 32'(db), 32'(pushed_st(exp_b)));
          sp_m--;
        end
        6: begin
          chk({tag, " R8 vec low"}, 32'(addr), 32'(vec));
          chk({tag, " R8 set_i"}, 32'(set_i), 32'h1);
          chk({tag, " R7 pend clear"}, 32'(hw_pend), 32'h0);
        end
        default: chk({tag, " R9 vec high"}, 32'(addr), 32'(vec + 16'd1));
      endcase
      if (s == inj_step) begin
        if (inj_kind == 1) begin irq_n = 1'b0; i_flag = 1'b0; end
        else if (inj_kind == 2) nmi_taken = 1'b1;
      end
      @(negedge clk);
    end
    nmi_taken = 1'b0;
    irq_n     = 1'b1;
    chk({tag, " R4 back to idle"}, 32'(step), 32'h0);
  endtask

  task automatic t_reset_state;
    chk("R1 step", 32'(step), 32'h0);
    chk("R1 ir", 32'(ir), 32'hEA);
    chk("R1 pend", 32'(hw_pend), 32'h0);
    chk("R1 rw", 32'(rw), 32'h1);
    chk("R1 addr", 32'(addr), 32'h0);
    chk("R1 db", 32'(db), 32'h0);
  endtask

  task automatic t_reset_seq;
    res = 1'b1;
    @(negedge clk);
    chk("R4 reset holds step 1", 32'(step), 32'h1);
    chk("R11 reset read", 32'(rw), 32'h1);
    op_store = 1'b1;
    @(negedge clk);
    chk("R11 store suppressed in reset", 32'(rw), 32'h1);
    op_store = 1'b0;
    res = 1'b0;
    walk("reset", 16'hFFFC, 1'b0, 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_brk;
    sync = 1'b1; opcode = 8'h00;
    walk("brk", 16'hFFFE, 1'b1, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic t_irq_jam;
    irq_n = 1'b0;
    @(negedge clk);
    chk("R2 irq latched", 32'(hw_pend), 32'h1);
    irq_n = 1'b1; sync = 1'b1; opcode = 8'hA9;
    walk("irq_jam", 16'hFFFE, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_irq_masked;
    i_flag = 1'b1; irq_n = 1'b0;
    @(negedge clk);
    chk("R2 masked irq", 32'(hw_pend), 32'h0);
    irq_n = 1'b1; sync = 1'b1; opcode = 8'hA9;
    @(negedge clk);
    chk("R3 opcode loaded", 32'(ir), 32'hA9);
    chk("R3 no entry", 32'(step), 32'h0);
    sync = 1'b0; i_flag = 1'b0;
  endtask

  task automatic t_hijack;
    sync = 1'b1; opcode = 8'h00;
    walk("hijack R6", 16'hFFFE, 1'b1, 1'b1, 1'b0, 2, 1);
    chk("R7 pend after hijack", 32'(hw_pend), 32'h0);
  endtask

  task automatic t_nmi_in_brk;
    sync = 1'b1; opcode = 8'h00;
    walk("nmi_step5 R10", 16'hFFFA, 1'b1, 1'b1, 1'b1, 5, 2);
    chk("R10 nmi consumed", 32'(hw_pend), 32'h0);
  endtask

  task automatic t_late_nmi;
    sync = 1'b1; opcode = 8'h00;
    walk("late_nmi", 16'hFFFE, 1'b1, 1'b1, 1'b1, 6, 2);
    chk("R9 nmi still pending", 32'(hw_pend), 32'h1);
    sync = 1'b1; opcode = 8'hA9;
    walk("nmi_after R9", 16'hFFFA, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_php;
    php = 1'b1;
    @(negedge clk);
    chk("R11 php write", 32'(rw), 32'h0);
    chk("R6 php break bit 1", 32'(db), 32'(pushed_st(1'b1)));
    php = 1'b0;
    @(negedge clk);
    chk("R11 php ends", 32'(rw), 32'h1);
    irq_n = 1'b0;
    @(negedge clk);
    irq_n = 1'b1; php = 1'b1;
    @(negedge clk);
    chk("R6 php with pend", 32'(db), 32'(pushed_st(1'b0)));
    php = 1'b0; sync = 1'b1; opcode = 8'hA9;
    walk("php_clear", 16'hFFFE, 1'b1, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_store;
    op_store = 1'b1;
    @(negedge clk);
    chk("R11 store write", 32'(rw), 32'h0);
    op_store = 1'b0;
    @(negedge clk);
    chk("R11 store ends", 32'(rw), 32'h1);
  endtask

  task automatic t_rdy;
    sync = 1'b1; opcode = 8'h00;
    @(negedge clk);
    sync = 1'b0;
    @(negedge clk);
    chk("R12 at push hi", 32'(step), 32'h3);
    chk("R11 push hi write", 32'(rw), 32'h0);
    rdy = 1'b0;
    @(negedge clk);
    chk("R12 step held", 32'(step), 32'h3);
    chk("R12 rw read", 32'(rw), 32'h1);
    chk("R12 sp held", 32'(addr), {16'h0, 8'h01, sp_m});
    rdy = 1'b1;
    @(negedge clk);
    chk("R12 resumes", 32'(step), 32'h4);
    chk("R12 sp after", 32'(addr), {16'h0, 8'h01, sp_m - 8'd1});
    chk("R12 rw write", 32'(rw), 32'h0);
    sp_m = sp_m - 8'd3;
    repeat (4) @(negedge clk);
    chk("R12 finishes", 32'(step), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_seq();
    t_brk();
    t_irq_jam();
    t_irq_masked();
    t_hijack();
    t_nmi_in_brk();
    t_late_nmi();
    t_php();
    t_store();
    t_rdy();
    t_reset_seq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule